// File: doc/BRIEF.md
# SCL Half-Period Timer with Clock-Stretch Hold

This block sets the length of each SCL phase for an I2C master. The master controller raises a one-cycle request when a phase should start. The timer then captures a 7-bit reload value and counts it down to zero. It steps once every two oscillator clocks. At zero it emits a single-cycle tick and stops. It stays stopped until the next request.

A phase therefore lasts 2 × (reload + 1) oscillator clocks, and a full SCL period of two phases runs at f_osc / (4 × (reload + 1)). A slave may hold SCL low after the master has released it. In that case the timer does not load the count at once. It holds the request and loads only at the first clock edge where SCL is sampled high, or where the master takes SCL back. The stretched time is therefore not charged against the phase. The block has no streaming data path, so every pin is a plain control or status signal.

Top module: `scl_phase_timer`

## Requirements
- R1: After reset `tick_o` is low, and no tick appears until a request is accepted. A reset that arrives in the middle of a count abandons that count, and no tick follows it.
- R2: A request sampled at clock edge k, with SCL not held, loads `reload_i`. `tick_o` is then high in exactly the one cycle that follows edge k + 2·(reload+1).
- R3: The count steps once per two oscillator clocks, over the full 7-bit range. A reload of 0 gives a tick 2 cycles after the load edge, and a reload of 127 gives it 256 cycles after.
- R4: Each tick lasts one cycle. The timer then stays stopped, and no further tick appears until a new request is accepted.
- R5: A request that arrives while a count is running abandons that count. The count restarts from the new reload value, and the abandoned count produces no tick.
- R6: A request sampled on the same edge as the terminal step suppresses that tick and restarts the count.
- R7: SCL counts as held when `scl_rel_i` is 1 and `scl_in_i` is 0. A request made while SCL is held is deferred, and the timer stays stopped for as long as SCL remains held. The load happens at the first edge where SCL is no longer held, and the tick follows 2·(reload+1) cycles after that edge.
- R8: For a deferred request, the reload value is taken at the edge where the load happens, not at the edge where the request was made.
- R9: If the master takes SCL back (`scl_rel_i` drops to 0) while a request is deferred, the load happens at that edge even though `scl_in_i` is still low.
- R10: Changes on `reload_i` while a count is running do not affect that count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reload_i | input | 7 | Half-period reload value |
| load_req_i | input | 1 | One-cycle request to start or restart a phase |
| scl_in_i | input | 1 | Sampled SCL line level |
| scl_rel_i | input | 1 | 1 when the master has released SCL |
| tick_o | output | 1 | One-cycle pulse at the end of a phase |

## Verification
The assertions take `load_req_i` to be a one-cycle pulse from the controller. They also take `scl_in_i` to be already synchronized to `clk`. When a request is deferred, they take the controller to leave `scl_rel_i` unchanged except by an explicit take-back. The stimulus drives every input on the falling edge and raises a request for one cycle only. It changes SCL or the released flag only at planned points of a deferred request, so every sampled value is stable at the rising edge.

// File: rtl/sbg_pkg.sv
package sbg_pkg;
  localparam int unsigned SBG_RELOAD_W = 7;

  typedef enum logic {
    ARB_IDLE = 1'b0,
    ARB_HOLD = 1'b1
  } arb_state_e;
endpackage

// File: rtl/sbg_arbiter.sv
module sbg_arbiter
  import sbg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load_req_i,
  input  logic scl_in_i,
  input  logic scl_rel_i,
  output logic load_o,
  output logic cancel_o,
  output logic holding_o
);
  arb_state_e state_q, state_d;
  logic       line_held;

  assign line_held = scl_rel_i && !scl_in_i;
  assign cancel_o  = load_req_i;
  assign holding_o = (state_q == ARB_HOLD);

  always_comb begin
    load_o  = 1'b0;
    state_d = state_q;
    if (load_req_i) begin
      load_o  = !line_held;
      state_d = line_held ? ARB_HOLD : ARB_IDLE;
    end else if (state_q == ARB_HOLD && !line_held) begin
      load_o  = 1'b1;
      state_d = ARB_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ARB_IDLE;
    else        state_q <= state_d;
  end

  AST_HOLD_BLOCKS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ARB_HOLD && scl_rel_i && !scl_in_i && !load_req_i) |=> (state_q == ARB_HOLD)); // R7
endmodule

// File: rtl/sbg_phase.sv
module sbg_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic run_i,
  output logic step_o
);
  logic ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ph_q <= 1'b0;
    else if (load_i) ph_q <= 1'b0;
    else if (run_i)  ph_q <= ~ph_q;
    else             ph_q <= 1'b0;
  end

  assign step_o = run_i && ph_q;

  AST_STEP_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
    step_o |=> !step_o); // R3
endmodule

// File: rtl/sbg_counter.sv
module sbg_counter #(
  parameter int unsigned RELOAD_W = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_i,
  input  logic                cancel_i,
  input  logic                step_i,
  input  logic [RELOAD_W-1:0] reload_i,
  output logic                run_o,
  output logic                tick_o
);
  localparam logic [RELOAD_W-1:0] CNT_ZERO = '0;

  logic [RELOAD_W-1:0] cnt_q;
  logic                run_q;
  logic                tick_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= CNT_ZERO;
      run_q  <= 1'b0;
      tick_q <= 1'b0;
    end else if (load_i) begin
      cnt_q  <= reload_i;
      run_q  <= 1'b1;
      tick_q <= 1'b0;
    end else if (cancel_i) begin
      run_q  <= 1'b0;
      tick_q <= 1'b0;
    end else if (run_q && step_i) begin
      if (cnt_q == CNT_ZERO) begin
        run_q  <= 1'b0;
        tick_q <= 1'b1;
      end else begin
        cnt_q  <= cnt_q - 1'b1;
        tick_q <= 1'b0;
      end
    end else begin
      tick_q <= 1'b0;
    end
  end

  assign run_o  = run_q;
  assign tick_o = tick_q;

  AST_LOAD_CAPTURES: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (run_q && cnt_q == $past(reload_i))); // R2
  AST_COUNT_NEVER_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !load_i) |=> (cnt_q <= $past(cnt_q))); // R10
endmodule

// File: rtl/scl_phase_timer.sv
module scl_phase_timer
  import sbg_pkg::*;
#(
  parameter int unsigned RELOAD_W = SBG_RELOAD_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [RELOAD_W-1:0] reload_i,
  input  logic                load_req_i,
  input  logic                scl_in_i,
  input  logic                scl_rel_i,
  output logic                tick_o
);
  logic load_w, cancel_w, holding_w, step_w, run_w;

  sbg_arbiter u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_req_i (load_req_i),
    .scl_in_i   (scl_in_i),
    .scl_rel_i  (scl_rel_i),
    .load_o     (load_w),
    .cancel_o   (cancel_w),
    .holding_o  (holding_w)
  );

  sbg_phase u_phase (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load_w),
    .run_i  (run_w),
    .step_o (step_w)
  );

  sbg_counter #(.RELOAD_W(RELOAD_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load_w),
    .cancel_i (cancel_w),
    .step_i   (step_w),
    .reload_i (reload_i),
    .run_o    (run_w),
    .tick_o   (tick_o)
  );

  AST_TICK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o); // R4
  AST_TICK_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tick_o) |-> $past(run_w)); // R1
  AST_HELD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (holding_w && scl_rel_i && !scl_in_i) |-> !run_w); // R7
endmodule

// File: tb/test_scl_phase_timer.sv
module test_scl_phase_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] reload = '0;
  logic       load_req = 1'b0;
  logic       scl_in = 1'b1;
  logic       scl_rel = 1'b0;
  logic       tick;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  scl_phase_timer i_scl_phase_timer (
    .clk(clk), .rst_n(rst_n), .reload_i(reload), .load_req_i(load_req),
    .scl_in_i(scl_in), .scl_rel_i(scl_rel), .tick_o(tick)
  );

  // {reload, stretched, cycles SCL stays low}
  localparam int NV = 8;
  localparam int VEC [NV][3] = '{
    '{0, 0, 0}, '{1, 0, 0}, '{5, 0, 0}, '{127, 0, 0},
    '{3, 1, 0}, '{3, 1, 7}, '{0, 1, 4}, '{20, 1, 2}
  };

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog: actual=%0d cycles expected<=150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic start_load(input int r, input bit rel, input bit line);
    @(negedge clk);
    reload   = 7'(r);
    scl_rel  = rel;
    scl_in   = line;
    load_req = 1'b1;
    @(negedge clk);
  endtask

  // j=0 is the negedge right after the edge that sampled the request.
  // act: 1 SCL high, 2 master takes SCL, 3 new request, 4 new reload, 5 new reload + SCL high
  task automatic observe(input int maxj, input int act_j, input int act, input int r2,
                         output int first, output int ticks);
    first = -1;
    ticks = 0;
    for (int j = 0; j < maxj; j++) begin
      load_req = 1'b0;
      if (tick) begin
        ticks++;
        if (first < 0) first = j;
      end
      if (j == act_j) begin
        case (act)
          1: scl_in = 1'b1;
          2: scl_rel = 1'b0;
          3: begin reload = 7'(r2); load_req = 1'b1; end
          4: reload = 7'(r2);
          5: begin reload = 7'(r2); scl_in = 1'b1; end
          default: ;
        endcase
      end
      @(negedge clk);
    end
    load_req = 1'b0;
  endtask

  task automatic idle_line();
    scl_rel = 1'b0;
    scl_in  = 1'b1;
  endtask

  initial begin
    int f, t, exp_l;
    string tag;
    repeat (3) @(negedge clk);
    check(tick == 1'b0, "R1 reset tick", tick, 0);
    rst_n = 1'b1;
    observe(20, -1, 0, 0, f, t);
    check(t == 0, "R1 no tick without request", t, 0);

    for (int v = 0; v < NV; v++) begin
      exp_l = 2 * (VEC[v][0] + 1) + (VEC[v][1] != 0 ? VEC[v][2] + 1 : 0);
      tag = (VEC[v][1] != 0) ? "R7" : ((VEC[v][0] == 0 || VEC[v][0] == 127) ? "R3" : "R2");
      start_load(VEC[v][0], VEC[v][1] != 0, VEC[v][1] == 0);
      observe(exp_l + 40, VEC[v][1] != 0 ? VEC[v][2] : -1, 1, 0, f, t);
      check(f == exp_l, {tag, " tick latency"}, f, exp_l);
      check(t == 1, "R4 single tick then stop", t, 1);
      idle_line();
    end

    // R5: restart mid-count
    start_load(10, 1'b0, 1'b1);
    observe(60, 5, 3, 3, f, t);
    check(f == 14, "R5 restart latency", f, 14);
    check(t == 1, "R5 abandoned count silent", t, 1);

    // R6: request on the terminal edge
    start_load(2, 1'b0, 1'b1);
    observe(40, 5, 3, 1, f, t);
    check(f == 10, "R6 terminal collision latency", f, 10);
    check(t == 1, "R6 suppressed tick", t, 1);

    // R8: reload taken at the deferred load edge
    start_load(5, 1'b1, 1'b0);
    observe(60, 3, 5, 2, f, t);
    check(f == 10, "R8 deferred reload capture", f, 10);
    idle_line();

    // R9: master takes SCL back while deferred
    start_load(4, 1'b1, 1'b0);
    observe(60, 2, 2, 0, f, t);
    check(f == 13, "R9 take-back load", f, 13);
    idle_line();

    // R10: reload change mid-count ignored
    start_load(6, 1'b0, 1'b1);
    observe(60, 4, 4, 0, f, t);
    check(f == 14, "R10 reload change ignored", f, 14);

    // R7: long hold keeps timer stopped, then resumes
    start_load(3, 1'b1, 1'b0);
    observe(100, -1, 0, 0, f, t);
    check(t == 0, "R7 no tick while held", t, 0);
    observe(30, 0, 1, 0, f, t);
    check(f == 9, "R7 latency after release", f, 9);
    idle_line();

    // R1: reset mid-count abandons count
    start_load(50, 1'b0, 1'b1);
    repeat (10) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(tick == 1'b0, "R1 tick low in reset", tick, 0);
    rst_n = 1'b1;
    observe(200, -1, 0, 0, f, t);
    check(t == 0, "R1 no tick after reset", t, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule